// File: doc/BRIEF.md
# Console Serial Receiver with Status Registers

This block receives asynchronous serial characters on a single input line and presents them through two 32-bit registers: a control/status word and a receive data word. A free-running oversample tick, sixteen per bit time, paces the receiver. The serial input passes through a two-flop synchronizer and then reaches a framing state machine. That machine validates the start bit at its midpoint, samples eight data bits at mid-bit with the least significant bit first, and checks one stop bit. There is no parity bit.

Alongside the framer, a space detector counts oversample ticks while the line is held at space. Once it has seen twenty bit times of space, it posts a break. The break is reported with the next completed character, and the detector does not post again until the line has returned to mark. Status flags record a waiting character, an overrun, a framing fault and a break. Reading the data word clears the flags. A read/write enable bit gates an interrupt request that reflects the ready flag.

The framer has four states. FR_IDLE waits for the line to go to space and moves to FR_START on that tick. FR_START counts to the bit midpoint. If the line is back at mark there, it returns to FR_IDLE (false start). Otherwise it moves to FR_DATA. FR_DATA samples one bit at the end of each bit period and moves to FR_STOP after the eighth bit. FR_STOP samples the stop bit at the end of its period, emits a completion pulse and returns to FR_IDLE.

Top module: `console_rx_unit`

## Requirements
- R1: A frame of one space start bit, eight data bits sent least significant bit first and one stop bit is received, and its byte appears in data word bits 7:0.
- R2: A space pulse on the idle line that has returned to mark by the midpoint of the start bit is discarded and does not set the ready flag.
- R3: In the data word, bits 31:16, 12 and 10:8 read as zero, and a write to the data word (reg_sel=1) changes nothing.
- R4: Control word bit 7 (ready) sets when a character completes and clears when the data word is read.
- R5: Control word bit 6 is a read/write interrupt enable, the other control bits read zero, and irq is high exactly when bits 7 and 6 are both set.
- R6: Data word bit 14 (overrun) sets when a character completes while the previous one is still unread.
- R7: Data word bit 13 (framing) sets when the stop bit of the current character is sampled at space.
- R8: Data word bit 15 equals the OR of bits 14 and 13.
- R9: Data word bit 11 (break) sets at the end of a character once the line has been at space for 20 bit times, and a break also sets bit 13.
- R10: After a break is flagged, no further break is flagged until the line returns to mark and then holds space for another 20 bit times.
- R11: A read of the data word clears bits 14, 13 and 11, and each completed character re-evaluates those bits.
- R12: After reset, the ready flag, the interrupt enable and all error flags are clear and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial line, mark = 1, space = 0 |
| os_tick | input | 1 | One-cycle pulse, 16 per bit time |
| reg_sel | input | 1 | 0 selects the control word, 1 the data word |
| rd_en | input | 1 | Read strobe; a data word read clears status |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Selected register contents |
| irq | output | 1 | Interrupt request |

## Verification
Random bytes with clean stop bits show that the byte is assembled in the right order and that no flag is raised falsely. Deliberately bad stop bits separate the framing flag from the break flag. Two frames sent without a read in between isolate the overrun flag. A short space glitch tells a real start bit from a rejected one. A line held at space for 22 bit times tests how the break is reported. A line held at space for 50 bit times, read partway through, tests that the break does not re-flag until the line has returned to mark. Writes with every bit set show which control bits are writable and that the data word ignores writes.

// File: rtl/conrx_pkg.sv
package conrx_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_e;

    localparam int CHAR_W   = 8;
    localparam int POS_RDY  = 7;
    localparam int POS_IE   = 6;
    localparam int POS_ERR  = 15;
    localparam int POS_OVR  = 14;
    localparam int POS_FRM  = 13;
    localparam int POS_BRK  = 11;
endpackage

// File: rtl/conrx_sync.sv
module conrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/conrx_framer.sv
module conrx_framer
    import conrx_pkg::*;
#(
    parameter int OS   = 16,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          stop_bad
);
    localparam int CW   = $clog2(OS);
    localparam int BW   = $clog2(DW);
    localparam int MID  = OS/2 - 1;
    localparam int LAST = OS - 1;

    fr_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [BW-1:0]   idx_q;
    logic [DW-1:0]   shreg_q;
    logic            mid_hit, end_hit, last_bit;

    assign mid_hit  = tick && (cnt_q == CW'(MID));
    assign end_hit  = tick && (cnt_q == CW'(LAST));
    assign last_bit = (idx_q == BW'(DW-1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (tick && !line)       state_d = FR_START;
            FR_START: if (mid_hit)             state_d = line ? FR_IDLE : FR_DATA;
            FR_DATA:  if (end_hit && last_bit) state_d = FR_STOP;
            FR_STOP:  if (end_hit)             state_d = FR_IDLE;
            default:                           state_d = FR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            shreg_q  <= '0;
            done     <= 1'b0;
            data     <= '0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    FR_IDLE: begin
                        cnt_q <= '0;
                        idx_q <= '0;
                    end
                    FR_START: cnt_q <= mid_hit ? '0 : cnt_q + CW'(1);
                    FR_DATA: begin
                        cnt_q <= end_hit ? '0 : cnt_q + CW'(1);
                        if (end_hit) begin
                            shreg_q <= {line, shreg_q[DW-1:1]};
                            idx_q   <= last_bit ? '0 : idx_q + BW'(1);
                        end
                    end
                    FR_STOP: begin
                        cnt_q <= end_hit ? '0 : cnt_q + CW'(1);
                        if (end_hit) begin
                            done     <= 1'b1;
                            data     <= shreg_q;
                            stop_bad <= ~line;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/conrx_brk_det.sv
module conrx_brk_det #(
    parameter int OS       = 16,
    parameter int BRK_BITS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic consume,
    output logic pending
);
    localparam int LIM = OS * BRK_BITS;
    localparam int SW  = $clog2(LIM + 1);

    logic [SW-1:0] space_q;
    logic          armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            space_q <= '0;
            armed_q <= 1'b1;
            pending <= 1'b0;
        end else begin
            if (line) begin
                space_q <= '0;
                armed_q <= 1'b1;
            end else if (tick && space_q != SW'(LIM)) begin
                space_q <= space_q + SW'(1);
            end
            if (consume) pending <= 1'b0;
            if (!line && armed_q && space_q == SW'(LIM)) begin
                pending <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/console_rx_unit.sv
module console_rx_unit
    import conrx_pkg::*;
#(
    parameter int OS       = 16,
    parameter int BRK_BITS = 20,
    parameter int SYNC_N   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_in,
    input  logic        os_tick,
    input  logic        reg_sel,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq
);
    logic              line_s;
    logic              char_done;
    logic [CHAR_W-1:0] char_val;
    logic              char_bad;
    logic              brk_pend;

    logic              ready_q, ie_q, ovr_q, frm_q, brk_q;
    logic [CHAR_W-1:0] char_q;
    logic              data_rd;
    logic [31:0]       ctrl_word, data_word;

    conrx_sync #(.STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(ser_in), .q_out(line_s)
    );

    conrx_framer #(.OS(OS), .DW(CHAR_W)) framer_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
        .done(char_done), .data(char_val), .stop_bad(char_bad)
    );

    conrx_brk_det #(.OS(OS), .BRK_BITS(BRK_BITS)) brk_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
        .consume(char_done), .pending(brk_pend)
    );

    assign data_rd = rd_en && reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            ie_q    <= 1'b0;
            ovr_q   <= 1'b0;
            frm_q   <= 1'b0;
            brk_q   <= 1'b0;
            char_q  <= '0;
        end else begin
            if (wr_en && !reg_sel) ie_q <= wr_data[POS_IE];
            if (char_done) begin
                char_q  <= char_val;
                ready_q <= 1'b1;
                ovr_q   <= ready_q && !data_rd;
                frm_q   <= char_bad || brk_pend;
                brk_q   <= brk_pend;
            end else if (data_rd) begin
                ready_q <= 1'b0;
                ovr_q   <= 1'b0;
                frm_q   <= 1'b0;
                brk_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[POS_RDY] = ready_q;
        ctrl_word[POS_IE]  = ie_q;
        data_word          = '0;
        data_word[CHAR_W-1:0] = char_q;
        data_word[POS_BRK] = brk_q;
        data_word[POS_FRM] = frm_q;
        data_word[POS_OVR] = ovr_q;
        data_word[POS_ERR] = ovr_q | frm_q;
        rd_data = reg_sel ? data_word : ctrl_word;
    end

    assign irq = ready_q && ie_q;
endmodule

// File: rtl/conrx_checker.sv
module conrx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        irq,
    input logic        char_done,
    input logic        ready_q,
    input logic        ovr_q,
    input logic        brk_q,
    input logic        frm_q
);
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (irq == (rd_data[7] && rd_data[6]))); // R5

    AST_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rd_data[31:8] == 24'd0 && rd_data[5:0] == 6'd0)); // R5

    AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rd_data[31:16] == 16'd0 && !rd_data[12] && rd_data[10:8] == 3'd0)); // R3

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rd_data[15] == (rd_data[14] || rd_data[13]))); // R8

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> ready_q); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel && !char_done) |=> (!ready_q && !ovr_q && !frm_q && !brk_q)); // R11

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && ready_q && !(rd_en && reg_sel)) |=> ovr_q); // R6
endmodule

bind console_rx_unit conrx_checker chk_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq), .char_done(char_done),
    .ready_q(ready_q), .ovr_q(ovr_q), .brk_q(brk_q), .frm_q(frm_q)
);

// File: tb/console_rx_unit_tb.sv
`timescale 1ns/1ps
module console_rx_unit_tb_top;
    localparam int TICK_DIV = 4;
    localparam int OS       = 16;
    localparam int BITCLK   = TICK_DIV * OS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b1;
    logic        os_tick = 1'b0;
    logic        reg_sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int tdiv = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV-1);
    end

    console_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .os_tick(os_tick),
        .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] exp_data(logic [7:0] b, logic ovr, logic frm, logic brk);
        logic [31:0] w = '0;
        w[7:0] = b;
        w[11]  = brk;
        w[13]  = frm;
        w[14]  = ovr;
        w[15]  = ovr | frm;
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bits(int n);
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] b, logic stop_ok);
        @(negedge clk);
        ser_in = 1'b0; bits(1);
        for (int i = 0; i < 8; i++) begin
            ser_in = b[i]; bits(1);
        end
        ser_in = stop_ok; bits(1);
        ser_in = 1'b1; bits(2);
    endtask

    task automatic reg_read(logic sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic reg_write(logic sel, logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        reg_read(1'b0, v); check("R12 ctrl after reset", v, 32'h0);
        check("R12 irq after reset", {31'd0, irq}, 32'd0);
        reg_read(1'b1, v); check("R12 data flags after reset", v & 32'hFF00, 32'h0);

        // R5 interrupt enable
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_read(1'b0, v); check("R5 only enable writable", v, 32'h40);
        check("R5 irq low without ready", {31'd0, irq}, 32'd0);

        // R1 R4 R5 first character
        send_frame(8'hA5, 1'b1);
        check("R5 irq with ready and enable", {31'd0, irq}, 32'd1);
        reg_read(1'b0, v); check("R4 ready set", v, 32'hC0);
        reg_write(1'b1, 32'hFFFF_FFFF);
        reg_read(1'b1, v); check("R3 data write ignored", v, exp_data(8'hA5, 0, 0, 0));
        reg_read(1'b0, v); check("R4 ready cleared by data read", v, 32'h40);
        check("R5 irq low after read", {31'd0, irq}, 32'd0);
        reg_write(1'b0, 32'h0);

        // R1 random bytes
        for (int k = 0; k < 12; k++) begin
            b = 8'($urandom);
            send_frame(b, 1'b1);
            reg_read(1'b1, v); check("R1 random byte", v, exp_data(b, 0, 0, 0));
        end

        // R7 framing error, R8
        send_frame(8'h3C, 1'b0);
        reg_read(1'b1, v); check("R7 R8 framing flag", v, exp_data(8'h3C, 0, 1, 0));
        reg_read(1'b1, v); check("R11 flags cleared by read", v & 32'hFF00, 32'h0);

        // R6 overrun
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        reg_read(1'b1, v); check("R6 R8 overrun flag", v, exp_data(8'h22, 1, 0, 0));
        send_frame(8'h5A, 1'b1);
        reg_read(1'b1, v); check("R11 re-evaluated next char", v, exp_data(8'h5A, 0, 0, 0));

        // R2 false start
        @(negedge clk); ser_in = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        ser_in = 1'b1; bits(14);
        reg_read(1'b0, v); check("R2 glitch rejected", v, 32'h0);

        // R9 break held 22 bit times
        @(negedge clk); ser_in = 1'b0; bits(22);
        ser_in = 1'b1; bits(15);
        reg_read(1'b1, v); check("R9 break and framing", v & 32'hFF00, 32'h0000_E800);
        reg_read(1'b1, v); check("R11 break cleared by read", v & 32'hFF00, 32'h0);

        // R10 long space: flagged once, not again without a mark
        @(negedge clk); ser_in = 1'b0; bits(31);
        reg_read(1'b1, v); check("R10 first break flagged", v & 32'hFF00, 32'h0000_E800);
        bits(19);
        ser_in = 1'b1; bits(12);
        reg_read(1'b1, v); check("R10 no re-flag without mark", v & 32'hFF00, 32'h0000_C000);

        // R10 re-armed after mark
        @(negedge clk); ser_in = 1'b0; bits(22);
        ser_in = 1'b1; bits(15);
        reg_read(1'b1, v); check("R10 re-armed after mark", v & 32'h0800, 32'h0800);

        // R1 normal traffic afterwards
        send_frame(8'h81, 1'b1);
        reg_read(1'b1, v); check("R1 after break", v, exp_data(8'h81, 0, 0, 0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule